// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is a slave on a two-wire serial bus. It fronts a byte-wide memory built from inferred RAM. It watches sampled clock and data lines and finds bus start and stop conditions. It answers a control byte whose top four bits are the fixed device code 1010 and whose next three bits equal three strap inputs. It then takes a two-byte word address. After that it either stores written bytes or returns stored bytes. Data leaves the block through a pull-low enable, so the data line is only ever pulled low or released.

Written bytes first go into a page latch. They reach the array only when the master ends the transfer with a stop, and only if the write-protect input is low at that moment. A commit and a timed write window follow. While that window is open the block ignores its own address, so a master can poll it until it answers again. Reads start at an address loaded by a dummy write, or at the pointer left by the previous access. They continue for as long as the master acknowledges each byte.

The array depth is set by `ADDR_W`, the number of word-address bits. The default is 10. Setting it to 15 gives the full 32768-byte array.

Top module: `ee_i2c_slave`

## Requirements
- R1: A control byte of 1010 followed by the three strap bits is acknowledged: the pull-low enable is high during the ninth clock. Control bit 0 selects read when it is 1 and write when it is 0.
- R2: A control byte whose device code or strap bits differ is not acknowledged, and the block stays silent until the next start.
- R3: A byte written to address A and followed by a stop is returned by a later random read of A. The random read is a write-mode control byte, two address bytes with the high byte first, a repeated start, and then a read-mode control byte.
- R4: Within a page write the low 6 address bits advance and wrap inside the 64-byte page. Bytes past the 64th overwrite the earlier bytes in the same page.
- R5: Written bytes reach the array only at a stop. A repeated start after data bytes discards them.
- R6: When write-protect is high at the stop, the array is unchanged and no write window starts. Reads work whatever the write-protect level.
- R7: After a committed write, busy goes high for the commit plus `WC_CYCLES` clocks. During that time a matching control byte is not acknowledged.
- R8: A sequential read returns consecutive bytes while the master acknowledges, and it wraps from the top address (2^ADDR_W - 1) to 0.
- R9: A current-address read (a read-mode control byte right after a start) returns the byte one past the last byte accessed.
- R10: A master not-acknowledge after a read byte ends the read, and the block releases the data line.
- R11: After reset, busy is low and the data line is released.
- R12: The pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| dev_sel | input | 3 | Strap bits compared with control-byte bits 3..1 |
| wp_in | input | 1 | Write protect, high blocks commits |
| sda_low_o | output | 1 | Pulls the data line low when high |
| busy_o | output | 1 | High during commit and the write window |

## Verification
Control bytes are sent with a correct address, a wrong strap field and a wrong device code. This shows that the address match uses both fields. A single byte write is followed by polling during the busy window and then a random read, which separates the commit from the refusal window. A 66-byte page write, read back in full, shows the wrap inside the page and the overwrite. A protected write and an aborted write, each read back afterwards, show that the array was left untouched. A read that crosses the top address and ends with a not-acknowledge, followed by a current-address read, shows the pointer wrap, the pointer kept across transactions and the release of the data line.

// File: rtl/ee_pkg.sv
package ee_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL,
        S_AHI,
        S_ALO,
        S_WR,
        S_RD
    } ee_st_e;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/ee_cond_det.sv
module ee_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    typedef struct packed {
        logic [1:0] scl_m;
        logic [1:0] sda_m;
        logic       scl_p;
        logic       sda_p;
    } det_t;

    det_t r_d, r_q;

    always_comb begin
        r_d.scl_m = {r_q.scl_m[0], scl_in};
        r_d.sda_m = {r_q.sda_m[0], sda_in};
        r_d.scl_p = r_q.scl_m[1];
        r_d.sda_p = r_q.sda_m[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;
        else        r_q <= r_d;
    end

    assign scl_s    = r_q.scl_m[1];
    assign sda_s    = r_q.sda_m[1];
    assign scl_rise = scl_s & ~r_q.scl_p;
    assign scl_fall = ~scl_s & r_q.scl_p;
    assign start_p  = scl_s & r_q.scl_p & r_q.sda_p & ~sda_s;
    assign stop_p   = scl_s & r_q.scl_p & ~r_q.sda_p & sda_s;
endmodule

// File: rtl/ee_mem.sv
module ee_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_W    = 6,
    parameter int WC_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] dev_sel,
    input  logic       wp_in,
    output logic       sda_low_o,
    output logic       busy_o
);
    import ee_pkg::*;

    localparam int PAGE_N = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(WC_CYCLES + 1);
    localparam int PG_W   = ADDR_W - PAGE_W;

    typedef struct packed {
        ee_st_e                  st;
        ee_st_e                  nxt;
        logic [3:0]              bitcnt;
        logic                    ackph;
        logic                    mnack;
        logic [7:0]              sh;
        logic                    sda_low;
        logic [ADDR_W-1:0]       ptr;
        logic [7:0]              ahi;
        logic [PAGE_N-1:0][7:0]  lat;
        logic [PAGE_N-1:0]       msk;
        logic [PG_W-1:0]         pg;
        logic                    commit;
        logic [PAGE_W-1:0]       cidx;
        logic [CNT_W-1:0]        cnt;
    } ee_reg_t;

    ee_reg_t r_d, r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata, rdbyte;
    logic              busy;
    logic [2:0]        bi;

    ee_cond_det u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    ee_mem #(.AW(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (r_q.ptr),
        .rdata (rdbyte)
    );

    assign busy      = r_q.commit | (r_q.cnt != '0);
    assign mem_we    = r_q.commit & r_q.msk[r_q.cidx];
    assign mem_waddr = {r_q.pg, r_q.cidx};
    assign mem_wdata = r_q.lat[r_q.cidx];
    assign bi        = 3'd7 - r_q.bitcnt[2:0];

    always_comb begin
        r_d = r_q;

        // commit sweep through the page latch, then the timed window
        if (r_q.commit) begin
            r_d.cidx = r_q.cidx + PAGE_W'(1);
            if (r_q.cidx == PAGE_W'(PAGE_N - 1)) begin
                r_d.commit = 1'b0;
                r_d.msk    = '0;
                r_d.cnt    = CNT_W'(WC_CYCLES);
            end
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - CNT_W'(1);
        end

        if (start_p) begin
            r_d.st      = S_CTRL;
            r_d.bitcnt  = '0;
            r_d.ackph   = 1'b0;
            r_d.sda_low = 1'b0;
            if (!r_q.commit) r_d.msk = '0;
        end else if (stop_p) begin
            if ((r_q.msk != '0) && !r_q.commit) begin
                if (!wp_in) begin
                    r_d.commit = 1'b1;
                    r_d.cidx   = '0;
                end else begin
                    r_d.msk = '0;
                end
            end
            r_d.st      = S_IDLE;
            r_d.ackph   = 1'b0;
            r_d.sda_low = 1'b0;
        end else begin
            case (r_q.st)
                S_IDLE: ;
                S_RD: begin
                    if (scl_rise) begin
                        if (r_q.ackph) r_d.mnack  = sda_s;
                        else           r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end
                    if (scl_fall) begin
                        if (!r_q.ackph) begin
                            if (r_q.bitcnt == 4'd8) begin
                                r_d.sda_low = 1'b0;
                                r_d.ackph   = 1'b1;
                                r_d.ptr     = r_q.ptr + ADDR_W'(1);
                            end else begin
                                r_d.sda_low = ~r_q.sh[bi];
                            end
                        end else if (!r_q.mnack) begin
                            r_d.sh      = rdbyte;
                            r_d.sda_low = ~rdbyte[7];
                            r_d.bitcnt  = '0;
                            r_d.ackph   = 1'b0;
                        end else begin
                            r_d.st      = S_IDLE;
                            r_d.sda_low = 1'b0;
                            r_d.ackph   = 1'b0;
                        end
                    end
                end
                default: begin
                    if (scl_rise && !r_q.ackph) begin
                        r_d.sh     = {r_q.sh[6:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end
                    if (scl_fall) begin
                        if (r_q.ackph) begin
                            r_d.ackph   = 1'b0;
                            r_d.bitcnt  = '0;
                            r_d.sda_low = 1'b0;
                            r_d.st      = r_q.nxt;
                            if (r_q.nxt == S_RD) begin
                                r_d.sh      = rdbyte;
                                r_d.sda_low = ~rdbyte[7];
                            end
                        end else if (r_q.bitcnt == 4'd8) begin
                            r_d.ackph   = 1'b1;
                            r_d.sda_low = 1'b1;
                            case (r_q.st)
                                S_CTRL: begin
                                    if ((r_q.sh[7:4] == DEV_CODE) && (r_q.sh[3:1] == dev_sel) && !busy) begin
                                        r_d.nxt = r_q.sh[0] ? S_RD : S_AHI;
                                    end else begin
                                        r_d.st      = S_IDLE;
                                        r_d.ackph   = 1'b0;
                                        r_d.sda_low = 1'b0;
                                    end
                                end
                                S_AHI: begin
                                    r_d.ahi = r_q.sh;
                                    r_d.nxt = S_ALO;
                                end
                                S_ALO: begin
                                    r_d.ptr = ADDR_W'({r_q.ahi, r_q.sh});
                                    r_d.pg  = r_d.ptr[ADDR_W-1:PAGE_W];
                                    r_d.msk = '0;
                                    r_d.nxt = S_WR;
                                end
                                default: begin
                                    r_d.lat[r_q.ptr[PAGE_W-1:0]] = r_q.sh;
                                    r_d.msk[r_q.ptr[PAGE_W-1:0]] = 1'b1;
                                    r_d.ptr[PAGE_W-1:0] = r_q.ptr[PAGE_W-1:0] + PAGE_W'(1);
                                    r_d.nxt = S_WR;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_low_o = r_q.sda_low;
    assign busy_o    = busy;
endmodule

// File: rtl/ee_chk.sv
module ee_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_low,
    input logic busy,
    input logic wp_in,
    input logic mem_we
);
    p_sda_change_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_s);

    p_wp_blocks_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_in));

    p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_low);

    p_write_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

bind ee_i2c_slave ee_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_low (sda_low_o),
    .busy    (busy_o),
    .wp_in   (wp_in),
    .mem_we  (mem_we)
);

// File: tb/tb_ee_i2c_slave.sv
module tb_ee_i2c_slave;
    localparam int H = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic sda_low, busy;
    logic sda_line;
    int   errors = 0;
    int   checks = 0;
    int   viol = 0;
    logic done = 1'b0;
    logic last_low = 1'b0;
    logic [7:0] wbuf [80];
    logic [7:0] rbuf [80];

    assign sda_line = ~(m_low | sda_low);

    always #10 clk = ~clk;

    ee_i2c_slave #(.ADDR_W(10), .PAGE_W(6), .WC_CYCLES(600)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .dev_sel   (STRAP),
        .wp_in     (wp),
        .sda_low_o (sda_low),
        .busy_o    (busy)
    );

    always @(negedge clk) begin
        if (rst_n && (sda_low !== last_low) && scl) viol++;
        last_low <= sda_low;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; wt(H);
        scl = 1'b1;   wt(H);
        m_low = 1'b1; wt(H);
        scl = 1'b0;   wt(2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(H);
        scl = 1'b1;   wt(H);
        m_low = 1'b0; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wt(H);
            scl = 1'b1;    wt(H);
            scl = 1'b0;    wt(2);
        end
        m_low = 1'b0; wt(H);
        scl = 1'b1;   wt(H/2);
        ack = ~sda_line;
        wt(H/2);
        scl = 1'b0;   wt(2);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wt(H);
            scl = 1'b1; wt(H/2);
            b[i] = sda_line;
            wt(H/2);
            scl = 1'b0;
        end
        m_low = ~nack; wt(H);
        scl = 1'b1;    wt(H);
        scl = 1'b0;    wt(2);
        m_low = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(CW, ack);     chk({7'd0, ack}, 8'd1, {tag, " R1 control ack"});
        send_byte(a[15:8], ack); chk({7'd0, ack}, 8'd1, {tag, " address-high ack"});
        send_byte(a[7:0], ack);  chk({7'd0, ack}, 8'd1, {tag, " address-low ack"});
        for (int k = 0; k < n; k++) send_byte(wbuf[k], ack);
        bus_stop();
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input string tag);
        logic ack;
        bus_start();
        send_byte(CW, ack);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(CR, ack); chk({7'd0, ack}, 8'd1, {tag, " R1 read control ack"});
        for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
        wt(H);
        chk({7'd0, sda_low}, 8'd0, {tag, " R10 released after nack"});
        bus_stop();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) wt(1);
        chk({7'd0, busy}, 8'd0, "R7 window ends");
    endtask

    task automatic t_reset();
        chk({7'd0, busy}, 8'd0, "R11 busy after reset");
        chk({7'd0, sda_line}, 8'd1, "R11 line released after reset");
    endtask

    task automatic t_address();
        logic ack;
        bus_start(); send_byte(CW, ack); bus_stop();
        chk({7'd0, ack}, 8'd1, "R1 matching control byte");
        bus_start(); send_byte({4'b1010, 3'b001, 1'b0}, ack); bus_stop();
        chk({7'd0, ack}, 8'd0, "R2 wrong strap bits");
        bus_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); bus_stop();
        chk({7'd0, ack}, 8'd0, "R2 wrong device code");
    endtask

    task automatic t_byte_write();
        logic ack;
        wbuf[0] = 8'h5A;
        do_write(16'h0123, 1, "R3");
        chk({7'd0, busy}, 8'd1, "R7 busy after stop");
        bus_start(); send_byte(CW, ack); bus_stop();
        chk({7'd0, ack}, 8'd0, "R7 poll refused while busy");
        wait_idle();
        do_read(16'h0123, 1, "R3");
        chk(rbuf[0], 8'h5A, "R3 random read of written byte");
    endtask

    task automatic t_page();
        logic [7:0] e;
        for (int k = 0; k < 66; k++) wbuf[k] = 8'h80 + 8'(k);
        do_write(16'h027E, 66, "R4");
        wait_idle();
        do_read(16'h0240, 64, "R4");
        for (int j = 0; j < 64; j++) begin
            if (j == 62)      e = 8'hC0;
            else if (j == 63) e = 8'hC1;
            else              e = 8'h82 + 8'(j);
            chk(rbuf[j], e, $sformatf("R4 page offset %0d", j));
        end
    endtask

    task automatic t_protect();
        wp = 1'b1;
        wbuf[0] = 8'h77;
        do_write(16'h0123, 1, "R6");
        wt(4);
        chk({7'd0, busy}, 8'd0, "R6 no window when protected");
        do_read(16'h0123, 1, "R6");
        chk(rbuf[0], 8'h5A, "R6 protected array unchanged, read works");
        wp = 1'b0;
    endtask

    task automatic t_abort();
        logic ack;
        bus_start();
        send_byte(CW, ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
        send_byte(8'h33, ack);
        bus_start();
        send_byte(CW, ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
        bus_start();
        send_byte(CR, ack);
        recv_byte(1'b1, rbuf[0]);
        bus_stop();
        wt(4);
        chk({7'd0, busy}, 8'd0, "R5 no window after aborted write");
        chk(rbuf[0], 8'h5A, "R5 repeated start discards data");
    endtask

    task automatic t_wrap();
        logic ack;
        wbuf[0] = 8'h11; wbuf[1] = 8'h12;
        do_write(16'h03FE, 2, "R8");
        wait_idle();
        wbuf[0] = 8'h21; wbuf[1] = 8'h22;
        do_write(16'h0000, 2, "R8");
        wait_idle();
        do_read(16'h03FE, 3, "R8");
        chk(rbuf[0], 8'h11, "R8 sequential byte 0");
        chk(rbuf[1], 8'h12, "R8 sequential top byte");
        chk(rbuf[2], 8'h21, "R8 wrap to address 0");
        bus_start();
        send_byte(CR, ack);
        recv_byte(1'b1, rbuf[0]);
        bus_stop();
        chk(rbuf[0], 8'h22, "R9 current-address read");
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_address();
        t_byte_write();
        t_page();
        t_protect();
        t_abort();
        t_wrap();
        checks++;
        if (viol != 0) begin
            errors++;
            $display("FAIL R12 pull-low changes during SCL high actual=%0d expected=0", viol);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule